// File: doc/BRIEF.md
# Snooping MESI Cache Line State Controller

This block keeps coherence state for the lines of a small private cache that sits on a shared snooping bus. It uses a direct-mapped tag/state array. Each line is Invalid, Shared, Exclusive or Modified. A processor presents one read or write request at a time and holds it until the block signals completion. Completion also tells the processor whether the access hit.

When a request needs the bus, the block raises a bus request with a command and a line address. It holds them until the bus grants. A grant cycle is also the cycle in which the transaction completes, and it carries the wired-OR shared response of the other caches.

At the same time the block watches transactions from other masters. In the cycle a snoop is presented, it answers combinationally on a shared output and a flush output. The new line state takes effect at the next clock edge. Data storage is not part of this block. A flush indication stands in for supplying the dirty data.

Addresses are line addresses. The low log2(LINES) bits select the line and the remaining bits form the tag. The bus serialises transactions, so a grant never arrives in the same cycle as a snoop. The processor holds its request stable until completion.

Top module: `mesiLineCtrl`

## Requirements
- R1: After reset every line is Invalid, and cpuDone, cpuHit, busReq, snpShared and snpFlush are all 0.
- R2: A read that misses raises busReq with busCmd 0 (read) at the request address. In the grant cycle cpuDone=1 and cpuHit=0. The line is installed Exclusive if busSharedIn was 0 in that cycle, and Shared if it was 1.
- R3: A write that misses raises busReq with busCmd 1 (read-exclusive) at the request address. The line is installed Modified in the grant cycle, with cpuDone=1 and cpuHit=0.
- R4: A read hit in Modified, Exclusive or Shared, and a write hit in Modified, complete in the request cycle with cpuDone=1, cpuHit=1 and no busReq.
- R5: A write hit on an Exclusive line completes in the request cycle with no busReq and leaves the line Modified.
- R6: A write hit on a Shared line raises busReq with busCmd 2 (upgrade), with no data fetch. In the grant cycle cpuDone=1 and cpuHit=1, and the line becomes Modified.
- R7: A snooped read (snpCmd 0) that matches a valid line asserts snpShared. A Modified line also asserts snpFlush and becomes Shared. An Exclusive line becomes Shared without a flush. A Shared line stays Shared.
- R8: A snooped read-exclusive (snpCmd 1) that matches a valid line makes it Invalid. snpFlush is asserted only if the line was Modified, and snpShared stays 0.
- R9: A snooped upgrade (snpCmd 2) that matches a Shared line makes it Invalid, with no flush. A snooped writeback (snpCmd 3), or a snoop whose tag does not match, changes nothing and asserts neither output.
- R10: A miss whose indexed line is Modified with another tag first requests busCmd 3 (writeback) at the victim's address. Once that is granted, it requests the fill for the new address.
- R11: Snoops are handled while a request is stalled. A processor request cannot complete in a snoop cycle. A snoop that invalidates a Shared line with a pending upgrade turns the request into a read-exclusive. A snoop that flushes a Modified victim removes the pending writeback.
- R12: Once raised, busReq stays high until the grant. Its command changes only after a snoop cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid, held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor line address |
| cpuDone | output | 1 | Request completes this cycle |
| cpuHit | output | 1 | With cpuDone: the line was present |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| busAddr | output | ADDR_W | Line address of the transaction |
| busGrant | input | 1 | Own transaction granted and completed this cycle |
| busSharedIn | input | 1 | Wired-OR shared response, valid with busGrant |
| snpValid | input | 1 | Another master's transaction is on the bus |
| snpCmd | input | 2 | Snooped command, same encoding as busCmd |
| snpAddr | input | ADDR_W | Snooped line address |
| snpShared | output | 1 | This cache holds a copy (drives the wired-OR) |
| snpFlush | output | 1 | This cache supplies dirty data |

## Verification
The bench targets the races between snoops and a stalled request. One case is an invalidating snoop arriving between a Shared-line write and its upgrade grant. A design that latched the command would then upgrade a line it no longer holds. Another case is a snooped read that cleans a Modified victim while its writeback waits. A design that missed this would write stale data back and fill late. Snoops that alias the same index with a different tag, and snooped writebacks, must leave state untouched. Later hits and misses show this, because a design that compared only the index would corrupt lines. The bench also drives snoops that coincide with hits, where a design lacking the snoop-first rule would apply both updates to one line in the same cycle.

// File: rtl/mesiPkg.sv
`timescale 1ns/1ps
package mesiPkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} lineState_t;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3} busCmd_t;

  // strobes from control to the tag/state array
  typedef struct packed {
    logic       cpuWrEn;
    lineState_t cpuWrState;
    logic       snpWrEn;
    lineState_t snpWrState;
  } arrStrobe_t;
endpackage

// File: rtl/mesiTagArray.sv
`timescale 1ns/1ps
module mesiTagArray
  import mesiPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  arrStrobe_t        strobe,
  output lineState_t        cpuState,
  output logic              cpuTagHit,
  output logic [ADDR_W-1:0] victimAddr,
  output lineState_t        snpState,
  output logic              snpTagHit
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t       stArr  [LINES];
  logic [TAG_W-1:0] tagArr [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // one state/tag register per line; the snoop port wins on a shared index
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stArr[g]  <= ST_I;
        tagArr[g] <= '0;
      end else if (strobe.snpWrEn && snpIdx == IDX_W'(g)) begin
        stArr[g]  <= strobe.snpWrState;
      end else if (strobe.cpuWrEn && cpuIdx == IDX_W'(g)) begin
        stArr[g]  <= strobe.cpuWrState;
        tagArr[g] <= cpuTag;
      end
    end
  end

  assign cpuState   = stArr[cpuIdx];
  assign cpuTagHit  = (tagArr[cpuIdx] == cpuTag);
  assign victimAddr = {tagArr[cpuIdx], cpuIdx};
  assign snpState   = stArr[snpIdx];
  assign snpTagHit  = (tagArr[snpIdx] == snpTag);
endmodule

// File: rtl/mesiCtrl.sv
`timescale 1ns/1ps
module mesiCtrl
  import mesiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  logic       busGrant,
  input  logic       busSharedIn,
  input  logic       snpValid,
  input  logic [1:0] snpCmd,
  input  lineState_t cpuState,
  input  logic       cpuTagHit,
  input  lineState_t snpState,
  input  logic       snpTagHit,
  output arrStrobe_t strobe,
  output logic       cpuDone,
  output logic       cpuHit,
  output logic       busReq,
  output busCmd_t    busCmd,
  output logic       selVictim,
  output logic       snpShared,
  output logic       snpFlush
);
  typedef enum logic {PH_IDLE, PH_BUS} phase_t;
  phase_t phase, phaseNext;

  logic cpuValid, needWb, snpHold;

  assign cpuValid = cpuTagHit && (cpuState != ST_I);
  assign needWb   = !cpuValid && (cpuState == ST_M);
  assign snpHold  = snpValid && snpTagHit && (snpState != ST_I);

  // snoop responder
  always_comb begin
    snpShared         = 1'b0;
    snpFlush          = 1'b0;
    strobe.snpWrEn    = 1'b0;
    strobe.snpWrState = ST_I;
    if (snpHold) begin
      unique case (busCmd_t'(snpCmd))
        CMD_RD: begin
          snpShared = 1'b1;
          snpFlush  = (snpState == ST_M);
          if (snpState != ST_S) begin
            strobe.snpWrEn    = 1'b1;
            strobe.snpWrState = ST_S;
          end
        end
        CMD_RDX: begin
          snpFlush       = (snpState == ST_M);
          strobe.snpWrEn = 1'b1;
        end
        CMD_UPG: strobe.snpWrEn = 1'b1;
        CMD_WB:  ;
        default: ;
      endcase
    end
  end

  // processor side
  always_comb begin
    phaseNext         = phase;
    cpuDone           = 1'b0;
    cpuHit            = 1'b0;
    busReq            = 1'b0;
    busCmd            = CMD_RD;
    selVictim         = 1'b0;
    strobe.cpuWrEn    = 1'b0;
    strobe.cpuWrState = ST_I;
    unique case (phase)
      PH_IDLE: begin
        if (cpuReq && !snpValid) begin
          if (cpuValid && !cpuWrite) begin
            cpuDone = 1'b1;
            cpuHit  = 1'b1;
          end else if (cpuValid && cpuState == ST_M) begin
            cpuDone = 1'b1;
            cpuHit  = 1'b1;
          end else if (cpuValid && cpuState == ST_E) begin
            cpuDone           = 1'b1;
            cpuHit            = 1'b1;
            strobe.cpuWrEn    = 1'b1;
            strobe.cpuWrState = ST_M;
          end else begin
            phaseNext = PH_BUS;
          end
        end
      end
      PH_BUS: begin
        busReq    = 1'b1;
        selVictim = needWb;
        if (needWb)                    busCmd = CMD_WB;
        else if (cpuValid && cpuWrite) busCmd = CMD_UPG;
        else if (cpuWrite)             busCmd = CMD_RDX;
        else                           busCmd = CMD_RD;
        if (busGrant) begin
          strobe.cpuWrEn = 1'b1;
          if (needWb) begin
            strobe.cpuWrState = ST_I;
          end else begin
            strobe.cpuWrState = cpuWrite ? ST_M : (busSharedIn ? ST_S : ST_E);
            cpuDone   = 1'b1;
            cpuHit    = cpuValid;
            phaseNext = PH_IDLE;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/mesiLineCtrl.sv
`timescale 1ns/1ps
module mesiLineCtrl
  import mesiPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGrant,
  input  logic              busSharedIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush
);
  arrStrobe_t        strobe;
  lineState_t        cpuState, snpState;
  logic              cpuTagHit, snpTagHit, selVictim;
  logic [ADDR_W-1:0] victimAddr;
  busCmd_t           cmdInt;

  mesiTagArray #(.ADDR_W(ADDR_W), .LINES(LINES)) uArr (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .snpAddr(snpAddr),
    .strobe(strobe), .cpuState(cpuState), .cpuTagHit(cpuTagHit),
    .victimAddr(victimAddr), .snpState(snpState), .snpTagHit(snpTagHit)
  );

  mesiCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .busGrant(busGrant), .busSharedIn(busSharedIn), .snpValid(snpValid),
    .snpCmd(snpCmd), .cpuState(cpuState), .cpuTagHit(cpuTagHit),
    .snpState(snpState), .snpTagHit(snpTagHit), .strobe(strobe),
    .cpuDone(cpuDone), .cpuHit(cpuHit), .busReq(busReq), .busCmd(cmdInt),
    .selVictim(selVictim), .snpShared(snpShared), .snpFlush(snpFlush)
  );

  assign busCmd  = cmdInt;
  assign busAddr = selVictim ? victimAddr : cpuAddr;
endmodule

// File: rtl/mesiLineCtrlChk.sv
`timescale 1ns/1ps
module mesiLineCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuDone,
  input logic       cpuHit,
  input logic       busReq,
  input logic [1:0] busCmd,
  input logic       busGrant,
  input logic       snpValid,
  input logic [1:0] snpCmd,
  input logic       snpShared,
  input logic       snpFlush
);
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGrant |=> busReq);
  p_cmd_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGrant && !snpValid |=> $stable(busCmd));
  p_flush_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> snpValid && (snpCmd == 2'd0 || snpCmd == 2'd1));
  p_shared_on_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    snpShared |-> snpValid && snpCmd == 2'd0);
  p_no_done_in_snoop_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !snpValid);
  p_fill_after_wb_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGrant && busCmd == 2'd3 |=> busReq);
  p_upgrade_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGrant && busCmd == 2'd2 |-> cpuDone && cpuHit);
  p_quiet_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone && !busGrant |-> cpuHit && !busReq);
endmodule

bind mesiLineCtrl mesiLineCtrlChk uChk (
  .clk(clk), .rstN(rstN), .cpuDone(cpuDone), .cpuHit(cpuHit),
  .busReq(busReq), .busCmd(busCmd), .busGrant(busGrant),
  .snpValid(snpValid), .snpCmd(snpCmd), .snpShared(snpShared),
  .snpFlush(snpFlush)
);

// File: tb/mesiLineCtrl_test.sv
`timescale 1ns/1ps
module mesiLineCtrl_test;
  localparam int AW = 16;
  localparam int L  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuWrite = 0, busGrant = 0, busSharedIn = 0, snpValid = 0;
  logic [AW-1:0] cpuAddr = '0, snpAddr = '0;
  logic [1:0] snpCmd = '0;
  logic cpuDone, cpuHit, busReq, snpShared, snpFlush;
  logic [1:0] busCmd;
  logic [AW-1:0] busAddr;

  always #2 clk = ~clk;

  mesiLineCtrl #(.ADDR_W(AW), .LINES(L)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuDone(cpuDone), .cpuHit(cpuHit), .busReq(busReq),
    .busCmd(busCmd), .busAddr(busAddr), .busGrant(busGrant),
    .busSharedIn(busSharedIn), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .snpShared(snpShared), .snpFlush(snpFlush)
  );

  // behavioural model: 0 invalid, 1 shared, 2 exclusive, 3 modified
  int  mSt[L];
  int  mTag[L];
  bit  mBusy;
  bit  lastDone;
  int  nChecks = 0, nFails = 0;
  bit  finished = 0;

  typedef struct {
    bit    isSnoop;
    bit    wr;
    int    addr;
    bit    sh;
    int    delay;
    int    snpAt;
    int    sCmd;
    int    sAddr;
    string tag;
  } op_t;
  op_t ops[$];

  task automatic check(input string tag, input bit eDone, eHit, eReq, eSh, eFl,
                       input int eCmd, eAddr);
    nChecks++;
    if (cpuDone !== eDone || cpuHit !== eHit || busReq !== eReq ||
        snpShared !== eSh || snpFlush !== eFl ||
        (eReq && (busCmd !== 2'(eCmd) || busAddr !== AW'(eAddr)))) begin
      nFails++;
      $display("FAIL %s: got done=%b hit=%b req=%b cmd=%0d addr=%h sh=%b fl=%b exp done=%b hit=%b req=%b cmd=%0d addr=%h sh=%b fl=%b",
               tag, cpuDone, cpuHit, busReq, busCmd, busAddr, snpShared, snpFlush,
               eDone, eHit, eReq, eCmd, eAddr[AW-1:0], eSh, eFl);
    end
  endtask

  // compute expected outputs for the present inputs, compare, then advance
  task automatic evalCycle(input string tag);
    int si, stg, ci, ctg, eCmd, eAddr, sNew, cNew;
    bit sHold, cValid, wb, eDone, eHit, eReq, eSh, eFl, sEn, cEn, busyNext;
    si = snpAddr % L; stg = snpAddr / L;
    ci = cpuAddr % L; ctg = cpuAddr / L;
    sHold = snpValid && mSt[si] != 0 && mTag[si] == stg;
    eSh = sHold && snpCmd == 0;
    eFl = sHold && mSt[si] == 3 && snpCmd <= 1;
    sEn = 0; sNew = 0;
    if (sHold) begin
      if (snpCmd == 0 && mSt[si] != 1) begin sEn = 1; sNew = 1; end
      if (snpCmd == 1 || snpCmd == 2)  begin sEn = 1; sNew = 0; end
    end
    cValid = mSt[ci] != 0 && mTag[ci] == ctg;
    eDone = 0; eHit = 0; eReq = 0; eCmd = 0; eAddr = 0; cEn = 0; cNew = 0;
    busyNext = mBusy;
    if (!mBusy) begin
      if (cpuReq && !snpValid) begin
        if (cValid && (!cpuWrite || mSt[ci] >= 2)) begin
          eDone = 1; eHit = 1;
          if (cpuWrite) begin cEn = 1; cNew = 3; end
        end else busyNext = 1;
      end
    end else begin
      eReq = 1;
      wb = !cValid && mSt[ci] == 3;
      if (wb) begin eCmd = 3; eAddr = mTag[ci] * L + ci; end
      else begin
        eAddr = cpuAddr;
        eCmd = (cValid && cpuWrite) ? 2 : (cpuWrite ? 1 : 0);
      end
      if (busGrant) begin
        cEn = 1;
        if (wb) cNew = 0;
        else begin
          cNew = cpuWrite ? 3 : (busSharedIn ? 1 : 2);
          eDone = 1; eHit = cValid; busyNext = 0;
        end
      end
    end
    check(tag, eDone, eHit, eReq, eSh, eFl, eCmd, eAddr);
    lastDone = eDone;
    if (cEn) begin mSt[ci] = cNew; mTag[ci] = ctg; end
    if (sEn) mSt[si] = sNew;
    mBusy = busyNext;
  endtask

  task automatic runOp(input op_t o);
    int cnt;
    cnt = 0;
    if (o.isSnoop) begin
      @(negedge clk);
      cpuReq = 0; snpValid = 1; snpCmd = 2'(o.sCmd); snpAddr = AW'(o.sAddr);
      #1 evalCycle(o.tag);
    end else begin
      lastDone = 0;
      for (int j = 0; j < 60 && !lastDone; j++) begin
        @(negedge clk);
        cpuReq = 1; cpuWrite = o.wr; cpuAddr = AW'(o.addr);
        busSharedIn = o.sh;
        snpValid = (j == o.snpAt);
        snpCmd = 2'(o.sCmd); snpAddr = AW'(o.sAddr);
        busGrant = mBusy && cnt >= o.delay && !snpValid;
        #1 evalCycle(o.tag);
        if (busGrant) cnt = 0; else if (mBusy) cnt++;
      end
      if (!lastDone) begin
        nChecks++; nFails++;
        $display("FAIL %s: request never completed, got done=0 exp done=1", o.tag);
      end
    end
    @(negedge clk);
    cpuReq = 0; snpValid = 0; busGrant = 0; busSharedIn = 0;
    #1 evalCycle(o.tag);
  endtask

  function automatic op_t cpuOp(bit wr, int addr, bit sh, int delay, string tag);
    op_t o;
    o.isSnoop = 0; o.wr = wr; o.addr = addr; o.sh = sh; o.delay = delay;
    o.snpAt = -1; o.sCmd = 0; o.sAddr = 0; o.tag = tag;
    return o;
  endfunction

  function automatic op_t snpOp(int cmd, int addr, string tag);
    op_t o;
    o = cpuOp(0, 0, 0, 0, tag);
    o.isSnoop = 1; o.sCmd = cmd; o.sAddr = addr;
    return o;
  endfunction

  function automatic op_t racyOp(bit wr, int addr, bit sh, int delay, int at,
                                 int cmd, int sAddr, string tag);
    op_t o;
    o = cpuOp(wr, addr, sh, delay, tag);
    o.snpAt = at; o.sCmd = cmd; o.sAddr = sAddr;
    return o;
  endfunction

  initial begin
    for (int i = 0; i < L; i++) begin mSt[i] = 0; mTag[i] = 0; end
    mBusy = 0;
    ops.push_back(cpuOp(0, 'h0010, 0, 2, "R2 read miss fills E"));
    ops.push_back(cpuOp(0, 'h0010, 0, 0, "R4 read hit E"));
    ops.push_back(cpuOp(1, 'h0010, 0, 0, "R5 write hit E silent"));
    ops.push_back(cpuOp(1, 'h0010, 0, 0, "R4 write hit M"));
    ops.push_back(snpOp(0, 'h0010, "R7 snoop read on M flushes"));
    ops.push_back(cpuOp(0, 'h0010, 0, 0, "R4 read hit S"));
    ops.push_back(cpuOp(1, 'h0010, 0, 3, "R6 write hit S upgrades R12"));
    ops.push_back(snpOp(1, 'h0010, "R8 snoop rdx on M flushes"));
    ops.push_back(cpuOp(0, 'h0010, 0, 1, "R8 line was invalidated"));
    ops.push_back(cpuOp(0, 'h0011, 1, 1, "R2 read miss fills S"));
    ops.push_back(snpOp(3, 'h0011, "R9 snoop writeback ignored"));
    ops.push_back(snpOp(0, 'h0091, "R9 alias tag ignored"));
    ops.push_back(snpOp(0, 'h0011, "R7 shared copy answers"));
    ops.push_back(snpOp(2, 'h0011, "R9 snoop upgrade invalidates"));
    ops.push_back(snpOp(0, 'h0011, "R9 invalid line silent"));
    ops.push_back(cpuOp(0, 'h0011, 0, 0, "R2 refill E"));
    ops.push_back(snpOp(0, 'h0011, "R7 snoop read on E no flush"));
    ops.push_back(cpuOp(1, 'h0022, 0, 2, "R3 write miss"));
    ops.push_back(cpuOp(0, 'h0122, 0, 2, "R10 evict M writes back"));
    ops.push_back(racyOp(1, 'h0011, 0, 2, 1, 1, 'h0011, "R11 upgrade turns rdx"));
    ops.push_back(cpuOp(1, 'h0033, 0, 1, "R3 write miss idx3"));
    ops.push_back(racyOp(0, 'h0133, 0, 2, 1, 0, 'h0033, "R11 snoop cleans victim"));
    ops.push_back(racyOp(0, 'h0122, 0, 0, 0, 0, 'h0003, "R11 snoop delays hit"));
    ops.push_back(cpuOp(1, 'h0122, 0, 0, "R5 write hit E idx2"));
    ops.push_back(snpOp(1, 'h0122, "R8 snoop rdx on M"));

    repeat (2) begin
      @(negedge clk);
      #1 check("R1 reset outputs", 0, 0, 0, 0, 0, 0, 0);
    end
    @(negedge clk);
    rstN = 1;
    #1 check("R1 idle after reset", 0, 0, 0, 0, 0, 0, 0);
    foreach (ops[k]) runOp(ops[k]);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule